// File: doc/BRIEF.md
# Sequenced Four-Function ALU with Shared Operand Port

This block is a small arithmetic unit split into a controller and a datapath. The controller is a Moore state machine. One start pulse walks it through a fixed run: capture the first operand, capture the second operand, compute and latch the result, then present that result.

Both operands come in on one shared 8-bit bus, one per cycle. An input steering stage routes the bus into whichever operand register the current state enables. The 2-bit operation select is used only in the compute cycle. The result register drives the output bus through an enable gate, so the bus carries a value only in the presentation cycle.

The surrounding logic drives the first operand during the cycle after start is seen, and the second operand in the cycle after that. It reads the result while the valid flag is high. The present state is brought out so the sequence can be observed.

Top module: `seq_alu_top`

## Requirements
- R1: A synchronous active-high `rst` puts the machine in the idle state (`state_o` = 0), drives `out_valid` low and `out_data` to 0, and clears the operand and result registers.
- R2: In idle, all controls are inactive and the machine stays idle until `start` is seen high at a clock edge. On that edge it moves to the first-load state (`state_o` = 1).
- R3: After leaving idle, the state advances once per clock in the fixed order 1 (load first operand), 2 (load second operand), 3 (compute), 4 (present), and then back to 0 (idle).
- R4: `start` has no effect outside idle. In particular, `start` held high during the present state still returns the machine to idle.
- R5: The first operand register captures `in_data` only at the edge that ends state 1, and the second operand register only at the edge that ends state 2. `in_data` in any other cycle does not affect the result.
- R6: `op_sel` is applied only during state 3, with the encoding 00 = add, 01 = subtract (first minus second), 10 = bitwise AND, 11 = bitwise OR. Add and subtract wrap modulo 256, and any carry or borrow is dropped.
- R7: `out_valid` is high only in state 4. During that cycle `out_data` equals the latched result. In every other cycle `out_data` is 0 (a released bus).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run; sampled only in idle |
| in_data | input | 8 | Shared operand bus |
| op_sel | input | 2 | Operation select, used in the compute state |
| out_data | output | 8 | Result while `out_valid` is high, otherwise 0 |
| out_valid | output | 1 | Output enable, high in the present state |
| state_o | output | 3 | Current controller state, 0 to 4 |

## Verification
The embedded properties assume that `rst` is a clean synchronous level and that `start`, `in_data` and `op_sel` change only away from the rising edge. The bench therefore drives every input on the falling edge. The properties also assume nothing about when `start` is released. To test that, the stimulus keeps `start` high through a whole run, and it puts deliberately wrong operand and operation values on the bus in every cycle where they must be ignored. Correct values appear only in the one cycle where each is consumed.

// File: rtl/seq_alu_pkg.sv
package seq_alu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOAD_A = 3'd1,
        ST_LOAD_B = 3'd2,
        ST_EXEC   = 3'd3,
        ST_SHOW   = 3'd4
    } ctl_state_t;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10,
        OP_OR  = 2'b11
    } alu_op_t;

    typedef struct packed {
        logic ld_a;
        logic ld_b;
        logic ld_r;
        logic drive;
    } ctl_bus_t;

endpackage

// File: rtl/seq_alu_ctrl.sv
module seq_alu_ctrl
    import seq_alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output ctl_bus_t   ctl,
    output ctl_state_t state
);

    typedef struct packed {
        ctl_state_t st;
    } ctrl_regs_t;

    ctrl_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.st)
            ST_IDLE:   regs_d.st = start ? ST_LOAD_A : ST_IDLE;
            ST_LOAD_A: regs_d.st = ST_LOAD_B;
            ST_LOAD_B: regs_d.st = ST_EXEC;
            ST_EXEC:   regs_d.st = ST_SHOW;
            ST_SHOW:   regs_d.st = ST_IDLE;
            default:   regs_d.st = ST_IDLE;
        endcase
        if (rst) begin
            regs_d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    // Moore decode: controls depend on the present state only
    always_comb begin
        ctl       = '0;
        ctl.ld_a  = (regs_q.st == ST_LOAD_A);
        ctl.ld_b  = (regs_q.st == ST_LOAD_B);
        ctl.ld_r  = (regs_q.st == ST_EXEC);
        ctl.drive = (regs_q.st == ST_SHOW);
    end

    assign state = regs_q.st;

    AST_IDLE_TO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start) |=> (state == ST_LOAD_A)); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !start) |=> (state == ST_IDLE)); // R2
    AST_A_TO_B: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD_A) |=> (state == ST_LOAD_B)); // R3
    AST_B_TO_EXEC: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD_B) |=> (state == ST_EXEC)); // R3
    AST_EXEC_TO_SHOW: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC) |=> (state == ST_SHOW)); // R3
    AST_SHOW_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHOW) |=> (state == ST_IDLE)); // R4
    AST_ONE_CONTROL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.ld_a, ctl.ld_b, ctl.ld_r, ctl.drive})); // R3

endmodule

// File: rtl/seq_alu_alu.sv
module seq_alu_alu
    import seq_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  alu_op_t      op,
    output logic [W-1:0] result
);

    always_comb begin
        unique case (op)
            OP_ADD:  result = opnd_a + opnd_b;
            OP_SUB:  result = opnd_a - opnd_b;
            OP_AND:  result = opnd_a & opnd_b;
            OP_OR:   result = opnd_a | opnd_b;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/seq_alu_dp.sv
module seq_alu_dp
    import seq_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  ctl_bus_t     ctl,
    input  logic [W-1:0] bus_in,
    input  alu_op_t      op,
    output logic [W-1:0] res_q_o
);

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] r;
    } dp_regs_t;

    dp_regs_t     regs_d, regs_q;
    logic [W-1:0] alu_out;

    seq_alu_alu #(.W(W)) u_alu (
        .opnd_a (regs_q.a),
        .opnd_b (regs_q.b),
        .op     (op),
        .result (alu_out)
    );

    always_comb begin
        regs_d = regs_q;
        // input steering: one shared bus feeds whichever operand is enabled
        if (ctl.ld_a) regs_d.a = bus_in;
        if (ctl.ld_b) regs_d.b = bus_in;
        if (ctl.ld_r) regs_d.r = alu_out;
        if (rst) regs_d = '0;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign res_q_o = regs_q.r;

    AST_A_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        ctl.ld_a |=> (regs_q.a == $past(bus_in))); // R5
    AST_A_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctl.ld_a |=> $stable(regs_q.a)); // R5
    AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctl.ld_b |=> $stable(regs_q.b)); // R5
    AST_R_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctl.ld_r |=> $stable(regs_q.r)); // R6

endmodule

// File: rtl/seq_alu_top.sv
module seq_alu_top
    import seq_alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] in_data,
    input  logic [1:0] op_sel,
    output logic [7:0] out_data,
    output logic       out_valid,
    output logic [2:0] state_o
);

    localparam int W = 8;

    ctl_bus_t     ctl;
    ctl_state_t   cur_state;
    logic [W-1:0] res_q;

    seq_alu_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctl   (ctl),
        .state (cur_state)
    );

    seq_alu_dp #(.W(W)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .bus_in  (in_data),
        .op      (alu_op_t'(op_sel)),
        .res_q_o (res_q)
    );

    // released bus modelled as zero, with a separate enable flag
    assign out_data  = ctl.drive ? res_q : '0;
    assign out_valid = ctl.drive;
    assign state_o   = cur_state;

    AST_VALID_ONLY_SHOW: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (state_o == 3'd4)); // R7
    AST_VALID_AFTER_EXEC: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(state_o == 3'd3)); // R7

endmodule

// File: tb/seq_alu_top_bench.sv
module seq_alu_top_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] in_data = '0;
    logic [1:0] op_sel = '0;
    logic [7:0] out_data;
    logic       out_valid;
    logic [2:0] state_o;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    seq_alu_top u_seq_alu_top (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .in_data   (in_data),
        .op_sel    (op_sel),
        .out_data  (out_data),
        .out_valid (out_valid),
        .state_o   (state_o)
    );

    // {a, b, op, expected}
    localparam logic [25:0] VECS [8] = '{
        {8'd200, 8'd100, 2'b00, 8'd44},
        {8'd255, 8'd1,   2'b00, 8'd0},
        {8'd10,  8'd20,  2'b01, 8'd246},
        {8'd0,   8'd1,   2'b01, 8'd255},
        {8'hF0,  8'h3C,  2'b10, 8'h30},
        {8'hA5,  8'h5A,  2'b11, 8'hFF},
        {8'd77,  8'd77,  2'b01, 8'd0},
        {8'h0F,  8'hFF,  2'b10, 8'h0F}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    // one full run with start held high and decoy values outside use cycles
    task automatic run(input logic [7:0] a, input logic [7:0] b,
                       input logic [1:0] op, input logic [7:0] exp);
        check("R2", state_o, 0);
        start = 1'b1; in_data = ~a; op_sel = op ^ 2'b01;
        step();
        check("R2", state_o, 1);
        check("R7", out_valid, 0);
        check("R7", out_data, 0);
        in_data = a; op_sel = ~op;
        step();
        check("R3", state_o, 2);
        in_data = b;
        step();
        check("R3", state_o, 3);
        in_data = 8'h5A ^ a; op_sel = op;
        step();
        check("R3", state_o, 4);
        check("R7", out_valid, 1);
        check("R6", out_data, exp);
        op_sel = ~op; in_data = ~b;
        step();
        check("R4", state_o, 0);
        check("R7", out_valid, 0);
        check("R7", out_data, 0);
        start = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        step();
        check("R1", state_o, 0);
        check("R1", out_valid, 0);
        check("R1", out_data, 0);
        rst = 1'b0;

        // R2: idle without start stays idle
        for (int i = 0; i < 5; i++) begin
            in_data = 8'(i * 37);
            step();
            check("R2", state_o, 0);
            check("R2", out_valid, 0);
        end

        // R5 R6 vector walk
        for (int i = 0; i < 8; i++) begin
            run(VECS[i][25:18], VECS[i][17:10], VECS[i][9:8], VECS[i][7:0]);
        end

        // R1: reset mid-run returns to idle
        start = 1'b1;
        step();
        start = 1'b0;
        step();
        check("R3", state_o, 2);
        rst = 1'b1;
        step();
        check("R1", state_o, 0);
        check("R1", out_valid, 0);
        rst = 1'b0;
        step();
        check("R1", state_o, 0);

        // R4: start during run does not restart; back-to-back runs
        run(8'd3, 8'd4, 2'b00, 8'd7);
        run(8'd4, 8'd3, 2'b01, 8'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule